// File: doc/BRIEF.md
# Hypercube Node Packet Router

This block is the forwarding element placed at every node of a binary n-cube message-passing network. It has one link port for each cube dimension, up to six, plus one local port through which the node's processor injects and receives packets. Every transfer is a 64-bit packet moved with a valid/ready handshake. The destination node number sits in a fixed header field. On each hop the router either delivers the packet to the local port or sends it toward the neighbour whose address differs in the lowest dimension where the current node and the destination still disagree. Each hop therefore removes one differing address bit.

Every port has a one-packet holding slot on the receive side and another on the send side. An output is shared by round-robin arbitration between the inputs that want it. A packet waits in its receive slot until it wins and the send slot it needs is empty. The node's own number and the number of active dimensions are captured while reset is held. A packet that arrives on a link outside the active cube is thrown away, and a sticky error flag is raised. Back-pressure rules: an input accepts a packet only when `in_ready` for that port is high. An output keeps `out_valid` and its data unchanged until `out_ready` is seen high at a clock edge.

Top module: `hcube_router`

## Requirements
- R1: After reset all `out_valid` bits and `err_drop` are low, and all `in_ready` bits are high.
- R2: The destination node number is bits 53:48 of the packet. A packet whose destination, masked to the active dimensions, equals the node number leaves on the local port (index 6). Its 64 bits are unchanged.
- R3: Any other packet leaves on link port k. Link port k has index k (0 to 5), and k is the lowest bit set in (destination XOR node number) over the active dimensions.
- R4: Destination and node-number bits at or above the active dimension count have no effect on the route.
- R5: A packet accepted on link port k with k at or above the active dimension count appears on no output. It sets `err_drop`, and `err_drop` then stays high until reset.
- R6: A packet accepted at clock edge e, whose route finds an empty output slot with no rival, shows `out_valid` after edge e+1 and not before.
- R7: While `out_valid` is high and `out_ready` is low, that output's valid and data stay constant. While an input's receive slot is occupied, its `in_ready` is low.
- R8: Inputs that contend for one output are served in rotating order, starting after the input served last. After reset the rotation starts at input 0.
- R9: Packets that enter on the same input and leave on the same output keep their order.
- R10: `cfg_node_id` (6 bits) and `cfg_dim` (1 to 6) are sampled only while `rst_n` is low. Changes to them after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; configuration is captured while low |
| cfg_node_id | input | 6 | Own node number |
| cfg_dim | input | 3 | Active cube dimension count, 1 to 6 |
| in_valid | input | 7 | Per-port packet offered (0-5 links, 6 local) |
| in_data | input | 448 | Per-port packet, port p in bits 64p+63:64p |
| in_ready | output | 7 | Per-port receive slot free |
| out_valid | output | 7 | Per-port packet available |
| out_data | output | 448 | Per-port outgoing packet, same packing |
| out_ready | input | 7 | Per-port downstream accepts |
| err_drop | output | 1 | Sticky flag: packet dropped on an inactive link |

## Verification
A packet accepted at edge e reaches the send slot at edge e+1. The bench drives inputs on falling edges and samples on falling edges. It checks that `out_valid` is still low half a cycle after the accepting edge and high one cycle later. A drop is recorded at the accepting edge, so `err_drop` is checked on the following falling edge, and all outputs are watched for several cycles to show that nothing emerges. For the arbitration and ordering cases, the output is held stalled so that contenders pile up. The stall is then released, and a log of completed handshakes taken at the rising edge is compared against the expected sequence.

// File: rtl/hcube_pkg.sv
`timescale 1ns/1ps
package hcube_pkg;
  localparam int unsigned HC_MAX_DIM  = 6;
  localparam int unsigned HC_PKT_W    = 64;
  localparam int unsigned HC_NODE_LSB = 48;
endpackage

// File: rtl/hcube_slot.sv
`timescale 1ns/1ps
module hcube_slot #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (push) begin
      full <= 1'b1;
      dout <= din;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  // R7
  slot_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/hcube_rr_arb.sv
`timescale 1ns/1ps
module hcube_rr_arb #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] grant
);
  localparam int unsigned IW = $clog2(N);

  logic [IW-1:0] ptr;
  logic [IW-1:0] gidx;
  logic          found;

  always_comb begin
    grant = '0;
    gidx  = '0;
    found = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      int j;
      j = int'(ptr) + i;
      if (j >= int'(N)) j = j - int'(N);
      if (!found && en && req[j]) begin
        grant[j] = 1'b1;
        gidx     = IW'(j);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (found) ptr <= (int'(gidx) == int'(N) - 1) ? '0 : gidx + 1'b1;
  end

  // R8
  arb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8
  arb_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (req != '0)) |-> (grant != '0));
endmodule

// File: rtl/hcube_route.sv
`timescale 1ns/1ps
module hcube_route #(
  parameter int unsigned MAX_DIM  = 6,
  parameter int unsigned PKT_W    = 64,
  parameter int unsigned NODE_LSB = 48
) (
  input  logic [PKT_W-1:0]   pkt,
  input  logic [MAX_DIM-1:0] node,
  input  logic [MAX_DIM-1:0] mask,
  output logic [MAX_DIM:0]   tgt
);
  logic [MAX_DIM-1:0] diff;
  int                 pick;

  always_comb begin
    diff = (pkt[NODE_LSB +: MAX_DIM] ^ node) & mask;
    tgt  = '0;
    pick = int'(MAX_DIM);
    for (int b = int'(MAX_DIM) - 1; b >= 0; b--) begin
      if (diff[b]) pick = b;
    end
    tgt[pick] = 1'b1;
  end
endmodule

// File: rtl/hcube_router.sv
`timescale 1ns/1ps
module hcube_router #(
  parameter int unsigned MAX_DIM  = hcube_pkg::HC_MAX_DIM,
  parameter int unsigned PKT_W    = hcube_pkg::HC_PKT_W,
  parameter int unsigned NODE_LSB = hcube_pkg::HC_NODE_LSB,
  localparam int unsigned NP      = MAX_DIM + 1,
  localparam int unsigned DIM_W   = $clog2(MAX_DIM + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAX_DIM-1:0]  cfg_node_id,
  input  logic [DIM_W-1:0]    cfg_dim,
  input  logic [NP-1:0]       in_valid,
  input  logic [NP*PKT_W-1:0] in_data,
  output logic [NP-1:0]       in_ready,
  output logic [NP-1:0]       out_valid,
  output logic [NP*PKT_W-1:0] out_data,
  input  logic [NP-1:0]       out_ready,
  output logic                err_drop
);
  logic [MAX_DIM-1:0] node_q;
  logic [DIM_W-1:0]   dim_q;
  logic [MAX_DIM-1:0] mask;
  logic               err_q;

  logic [NP-1:0]    in_full, in_pop, drop, out_full;
  logic [PKT_W-1:0] in_q   [NP];
  logic [PKT_W-1:0] out_q  [NP];
  logic [PKT_W-1:0] sel_q  [NP];
  logic [NP-1:0]    tgt    [NP];
  logic [NP-1:0]    req    [NP];
  logic [NP-1:0]    grant  [NP];

  // configuration captured while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      node_q <= cfg_node_id;
      dim_q  <= cfg_dim;
    end
  end

  always_comb begin
    for (int b = 0; b < int'(MAX_DIM); b++) mask[b] = (b < int'(dim_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (drop != '0) err_q <= 1'b1;
  end
  assign err_drop = err_q;

  // receive side
  for (genvar i = 0; i < int'(NP); i++) begin : g_in
    assign in_ready[i] = ~in_full[i];
    if (i < int'(MAX_DIM)) begin : g_link
      assign drop[i] = in_valid[i] & in_ready[i] & (int'(dim_q) <= i);
    end else begin : g_local
      assign drop[i] = 1'b0;
    end

    hcube_slot #(.W(PKT_W)) rx_slot_i (
      .clk  (clk),
      .rst_n(rst_n),
      .push (in_valid[i] & in_ready[i] & ~drop[i]),
      .din  (in_data[i*PKT_W +: PKT_W]),
      .pop  (in_pop[i]),
      .full (in_full[i]),
      .dout (in_q[i])
    );

    hcube_route #(.MAX_DIM(MAX_DIM), .PKT_W(PKT_W), .NODE_LSB(NODE_LSB)) route_i (
      .pkt (in_q[i]),
      .node(node_q),
      .mask(mask),
      .tgt (tgt[i])
    );
  end

  always_comb begin
    for (int o = 0; o < int'(NP); o++) begin
      for (int i = 0; i < int'(NP); i++) req[o][i] = in_full[i] & tgt[i][o];
    end
    in_pop = '0;
    for (int o = 0; o < int'(NP); o++) in_pop = in_pop | grant[o];
  end

  // send side
  for (genvar o = 0; o < int'(NP); o++) begin : g_out
    hcube_rr_arb #(.N(NP)) arb_i (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req[o]),
      .en   (~out_full[o]),
      .grant(grant[o])
    );

    always_comb begin
      sel_q[o] = '0;
      for (int i = 0; i < int'(NP); i++) begin
        if (grant[o][i]) sel_q[o] = sel_q[o] | in_q[i];
      end
    end

    hcube_slot #(.W(PKT_W)) tx_slot_i (
      .clk  (clk),
      .rst_n(rst_n),
      .push (grant[o] != '0),
      .din  (sel_q[o]),
      .pop  (out_valid[o] & out_ready[o]),
      .full (out_full[o]),
      .dout (out_q[o])
    );

    assign out_valid[o]              = out_full[o];
    assign out_data[o*PKT_W +: PKT_W] = out_q[o];

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_data[o*PKT_W +: PKT_W])));

    if (o < int'(MAX_DIM)) begin : g_fwd_chk
      localparam logic [MAX_DIM-1:0] LOWER = MAX_DIM'((1 << o) - 1);
      // R3
      fwd_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |-> ((((out_q[o][NODE_LSB +: MAX_DIM] ^ node_q) & mask) & LOWER) == '0
                          && (out_q[o][NODE_LSB + o] != node_q[o]) && mask[o]));
    end else begin : g_loc_chk
      // R2
      local_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |-> (((out_q[o][NODE_LSB +: MAX_DIM] ^ node_q) & mask) == '0));
    end
  end

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_drop |=> err_drop);
  // R7
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_full != '0) |-> ((in_ready & in_full) == '0));
endmodule

// File: tb/hcube_router_tb.sv
`timescale 1ns/1ps
module hcube_router_tb_top;
  localparam int NP = 7;
  localparam int LOC = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    cfg_node_id = 6'd10;
  logic [2:0]    cfg_dim = 3'd6;
  logic [NP-1:0] in_valid = '0;
  logic [NP*64-1:0] in_data = '0;
  logic [NP-1:0] in_ready;
  logic [NP-1:0] out_valid;
  logic [NP*64-1:0] out_data;
  logic [NP-1:0] out_ready = '1;
  logic          err_drop;

  int checks = 0;
  int errors = 0;
  logic [63:0] log_q [32];
  int log_n = 0;

  always #10 clk = ~clk;

  hcube_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_node_id(cfg_node_id), .cfg_dim(cfg_dim),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .err_drop(err_drop)
  );

  always @(posedge clk) begin
    if (out_valid[LOC] && out_ready[LOC] && log_n < 32) begin
      log_q[log_n] <= out_data[LOC*64 +: 64];
      log_n <= log_n + 1;
    end
  end

  function automatic logic [63:0] mk(input logic [5:0] dest, input logic [47:0] tag);
    return {10'h0, dest, tag};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [5:0] node, input logic [2:0] dim);
    @(negedge clk);
    rst_n = 1'b0; cfg_node_id = node; cfg_dim = dim;
    in_valid = '0; out_ready = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input int p, input logic [63:0] d);
    @(negedge clk);
    in_valid[p] = 1'b1;
    in_data[p*64 +: 64] = d;
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic expect_out(input int p, input logic [63:0] d, input string req);
    int n = 0;
    while (!out_valid[p] && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(out_valid[p], req, 64'(out_valid), 64'(1 << p));
    check(out_data[p*64 +: 64] == d, req, out_data[p*64 +: 64], d);
  endtask

  task automatic t_reset;
    do_reset(6'd10, 3'd6);
    check(out_valid == '0, "R1", 64'(out_valid), 64'd0);
    check(in_ready == '1, "R1", 64'(in_ready), 64'h7f);
    check(err_drop == 1'b0, "R1", 64'(err_drop), 64'd0);
  endtask

  task automatic t_local_latency;
    logic [63:0] d = mk(6'd10, 48'h1111);
    send(2, d);
    // R6: half a cycle after the accepting edge nothing is out yet
    check(out_valid[LOC] == 1'b0, "R6", 64'(out_valid[LOC]), 64'd0);
    @(negedge clk);
    check(out_valid[LOC] == 1'b1, "R6", 64'(out_valid[LOC]), 64'd1);
    check(out_data[LOC*64 +: 64] == d, "R2", out_data[LOC*64 +: 64], d);
  endtask

  task automatic t_forward;
    send(4, mk(6'd38, 48'h2));
    expect_out(2, mk(6'd38, 48'h2), "R3");
    send(LOC, mk(6'd43, 48'h3));
    expect_out(0, mk(6'd43, 48'h3), "R3");
    send(1, mk(6'd42, 48'h4));
    expect_out(5, mk(6'd42, 48'h4), "R3");
  endtask

  task automatic t_small_cube;
    do_reset(6'd10, 3'd3);
    // R10: configuration changes after reset are ignored
    cfg_node_id = 6'd5; cfg_dim = 3'd6;
    send(1, mk(6'd58, 48'h5));
    expect_out(LOC, mk(6'd58, 48'h5), "R4");
    send(2, mk(6'd59, 48'h6));
    expect_out(0, mk(6'd59, 48'h6), "R4");
    check(err_drop == 1'b0, "R5", 64'(err_drop), 64'd0);
    send(4, mk(6'd10, 48'h7));
    check(err_drop == 1'b1, "R5", 64'(err_drop), 64'd1);
    begin
      bit seen = 1'b0;
      repeat (5) begin
        @(negedge clk);
        if (out_valid != '0) seen = 1'b1;
      end
      check(!seen, "R5", 64'(seen), 64'd0);
    end
    send(0, mk(6'd10, 48'h8));
    expect_out(LOC, mk(6'd10, 48'h8), "R10");
    check(err_drop == 1'b1, "R5", 64'(err_drop), 64'd1);
  endtask

  task automatic t_round_robin;
    int base;
    do_reset(6'd10, 3'd6);
    out_ready[LOC] = 1'b0;
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      in_valid[p] = 1'b1;
      in_data[p*64 +: 64] = mk(6'd10, 48'hA0 + 48'(p));
    end
    @(negedge clk);
    in_valid = '0;
    send(0, mk(6'd10, 48'hB0));
    repeat (3) @(negedge clk);
    base = log_n;
    out_ready[LOC] = 1'b1;
    repeat (12) @(negedge clk);
    check(log_n - base == 4, "R8", 64'(log_n - base), 64'd4);
    check(log_q[base]   == mk(6'd10, 48'hA0), "R8", log_q[base],   mk(6'd10, 48'hA0));
    check(log_q[base+1] == mk(6'd10, 48'hA1), "R8", log_q[base+1], mk(6'd10, 48'hA1));
    check(log_q[base+2] == mk(6'd10, 48'hA2), "R8", log_q[base+2], mk(6'd10, 48'hA2));
    check(log_q[base+3] == mk(6'd10, 48'hB0), "R8", log_q[base+3], mk(6'd10, 48'hB0));
  endtask

  task automatic t_backpressure;
    int base;
    logic [63:0] p1 = mk(6'd10, 48'hC1);
    logic [63:0] p2 = mk(6'd10, 48'hC2);
    out_ready[LOC] = 1'b0;
    base = log_n;
    send(3, p1);
    send(3, p2);
    @(negedge clk);
    check(in_ready[3] == 1'b0, "R7", 64'(in_ready[3]), 64'd0);
    repeat (3) begin
      @(negedge clk);
      check(out_valid[LOC] && out_data[LOC*64 +: 64] == p1, "R7", out_data[LOC*64 +: 64], p1);
    end
    out_ready[LOC] = 1'b1;
    repeat (6) @(negedge clk);
    check(log_n - base == 2, "R9", 64'(log_n - base), 64'd2);
    check(log_q[base] == p1 && log_q[base+1] == p2, "R9", log_q[base], p1);
  endtask

  initial begin
    t_reset();
    t_local_latency();
    t_forward();
    t_round_robin();
    t_backpressure();
    t_small_cube();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule